// File: doc/BRIEF.md
# Indirect PCI Configuration Access Port

This block gives software a two-word window into PCI configuration space. A host bus writes a configuration address into a register at offset 0, then reads or writes a data window at offset 4. Each data-window access becomes one configuration request toward a downstream engine that runs the bus cycle. The request carries the bus, device, function and register number taken from the stored address. Read data, or all ones when no device answered, comes back to the host.

Some software writes ill-formed addresses: the enable bit is left clear, or the two low bits are set. The port repairs these on the way in. Every accepted address write stores the value with bit 31 forced to 1 and bits 1:0 forced to 0. Only a full-word write at offset 0 counts as an address write. Any other write there, and any write outside the two mapped offsets, is dropped without effect.

Host accesses are single-beat and little-endian: byte lane i is bits 8i+7:8i of the data word, and strobe bit i qualifies that lane. The port accepts one access at a time. It signals completion with a one-cycle done pulse.

Top module: `cfgwin_port`

## Requirements
- R1: After a synchronous active-low reset, the stored address is 0x00000000, `hst_ready` is 1, and both `cfg_req` and `hst_done` are 0.
- R2: A write at offset 0 with all four strobes set stores the written word with bit 31 set to 1 and bits 1:0 cleared. A read at offset 0 returns the stored word whatever its strobes are.
- R3: A write at offset 0 with any strobe clear leaves the stored address unchanged.
- R4: A write at an offset other than 0 or 4 has no effect. A read at such an offset returns 0x00000000.
- R5: While `cfg_req` is high, the target fields are taken from the stored address: `cfg_bus` is bits 23:16, `cfg_dev` is bits 15:11, `cfg_fn` is bits 10:8 and `cfg_reg` is bits 7:2.
- R6: An access at offset 4 with stored bit 31 set raises `cfg_req` in the cycle after acceptance. `cfg_we` equals the host write flag and `cfg_be` equals the host strobes. The request and all its fields stay unchanged until the cycle in which `cfg_ack` is high. `hst_done` pulses in the cycle after that. For a read, `hst_rdata` then equals `cfg_rdata`.
- R7: If `cfg_miss` is high together with `cfg_ack` on a read, the host receives 0xFFFFFFFF.
- R8: On a data-window write, each byte lane of `cfg_wdata` carries the host lane when its strobe is set and 0x00 when it is clear.
- R9: While stored bit 31 is 0, an access at offset 4 issues no request and completes in the cycle after acceptance. A read returns 0xFFFFFFFF.
- R10: While a request is outstanding, `hst_ready` is 0, and a host access presented then is not taken.
- R11: Any access not at offset 4 completes with `hst_done` high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_valid | input | 1 | Host access presented |
| hst_we | input | 1 | Host access is a write |
| hst_off | input | OFF_W | Byte offset within the port |
| hst_be | input | 4 | Host byte strobes, bit i for lane i |
| hst_wdata | input | 32 | Host write data |
| hst_ready | output | 1 | Port can take an access this cycle |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 32 | Read data, valid with `hst_done` |
| cfg_req | output | 1 | Configuration request outstanding |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword register number |
| cfg_be | output | 4 | Request byte enables |
| cfg_wdata | output | 32 | Request write data, disabled lanes zero |
| cfg_ack | input | 1 | Engine finished the request |
| cfg_miss | input | 1 | No device answered, valid with `cfg_ack` |
| cfg_rdata | input | 32 | Engine read data, valid with `cfg_ack` |

## Verification
The hardest case to reach is the disabled-address path of R9. Every address write forces bit 31 on, so stored bit 31 can be 0 only between reset and the first address write. The stimulus therefore exercises the disabled data window right after reset, before the vector table touches the address register. A second hazard is a host access that arrives while a request is outstanding. The bench holds a conflicting address write on the host port for the whole wait. Afterwards it reads the address back to show that the write was never taken.

// File: rtl/cfgwin_pkg.sv
// Package: shared constants, types and helpers for the configuration
// access port. Assumes a 32-bit little-endian host word and the standard
// type-1-style configuration address layout.
package cfgwin_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned LANES   = WORD_W / LANE_W;
    localparam int unsigned BUS_W   = 8;
    localparam int unsigned DEV_W   = 5;
    localparam int unsigned FN_W    = 3;
    localparam int unsigned REG_W   = 6;

    localparam int unsigned EN_BIT  = 31;
    localparam int unsigned BUS_LSB = 16;
    localparam int unsigned DEV_LSB = 11;
    localparam int unsigned FN_LSB  = 8;
    localparam int unsigned REG_LSB = 2;

    // Kind of host access after decoding
    typedef enum logic [2:0] {
        ACC_IDLE    = 3'd0,
        ACC_ADDR_WR = 3'd1,
        ACC_ADDR_RD = 3'd2,
        ACC_DATA    = 3'd3,
        ACC_NULL    = 3'd4
    } acc_kind_e;

    // Sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    // Target selected by the stored address
    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] regno;
    } cfg_target_t;

    // Repair an address word: enable forced on, dword alignment forced
    function automatic logic [WORD_W-1:0] repair_addr(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        r = v;
        r[REG_LSB-1:0] = '0;
        r[EN_BIT] = 1'b1;
        return r;
    endfunction

    // Expand byte strobes into a bit mask
    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < int'(LANES); i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfgwin_decode.sv
// Module: cfgwin_decode
// Classifies an accepted host access by offset, direction and strobes.
// Assumes take is already qualified with the port's ready signal.
module cfgwin_decode
    import cfgwin_pkg::*;
#(
    parameter int unsigned OFF_W    = 3,
    parameter int unsigned ADDR_OFF = 0,
    parameter int unsigned DATA_OFF = 4
) (
    input  logic             take,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    input  logic [LANES-1:0] be,
    output acc_kind_e        kind
);

    localparam logic [OFF_W-1:0] AOFF = OFF_W'(ADDR_OFF);
    localparam logic [OFF_W-1:0] DOFF = OFF_W'(DATA_OFF);

    logic full_word;
    assign full_word = &be;

    // Map offset, direction and strobe coverage to an access kind
    always_comb begin
        kind = ACC_IDLE;
        if (take) begin
            if (off == DOFF) begin
                kind = ACC_DATA;
            end else if (off == AOFF) begin
                if (!we) begin
                    kind = ACC_ADDR_RD;
                end else if (full_word) begin
                    kind = ACC_ADDR_WR;
                end else begin
                    kind = ACC_NULL;
                end
            end else begin
                kind = ACC_NULL;
            end
        end
    end

endmodule

// File: rtl/cfgwin_addr_reg.sv
// Module: cfgwin_addr_reg
// Holds the configuration address, repaired on every write, and splits it
// into target fields. Assumes wr_en is high only for full-word writes.
module cfgwin_addr_reg
    import cfgwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_val,
    output logic [WORD_W-1:0] addr_word,
    output logic              enabled,
    output cfg_target_t       target
);

    // Store the repaired address, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_word <= '0;
        end else if (wr_en) begin
            addr_word <= repair_addr(wr_val);
        end
    end

    // Split the stored word into its target fields
    always_comb begin
        enabled      = addr_word[EN_BIT];
        target.bus   = addr_word[BUS_LSB +: BUS_W];
        target.dev   = addr_word[DEV_LSB +: DEV_W];
        target.fn    = addr_word[FN_LSB  +: FN_W];
        target.regno = addr_word[REG_LSB +: REG_W];
    end

endmodule

// File: rtl/cfgwin_seq.sv
// Module: cfgwin_seq
// Runs one host access at a time. Register accesses complete at once; a
// data access with the enable bit set holds a request until the engine
// acknowledges. Assumes the engine acknowledges each request exactly once.
module cfgwin_seq
    import cfgwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic              acc_we,
    input  logic [LANES-1:0]  acc_be,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic [WORD_W-1:0] addr_word,
    input  logic              enabled,
    input  logic              cfg_ack,
    input  logic              cfg_miss,
    input  logic [WORD_W-1:0] cfg_rdata,
    output logic              ready,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              req,
    output logic              req_we,
    output logic [LANES-1:0]  req_be,
    output logic [WORD_W-1:0] req_wdata
);

    seq_state_e        state;
    logic [WORD_W-1:0] wdata_clean;

    // Zero the lanes whose strobe is clear
    for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
        assign wdata_clean[i*LANE_W +: LANE_W] =
            acc_be[i] ? acc_wdata[i*LANE_W +: LANE_W] : '0;
    end

    // Sequence accesses, capture request fields and form the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            done      <= 1'b0;
            rdata     <= '0;
            req_we    <= 1'b0;
            req_be    <= '0;
            req_wdata <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    case (kind)
                        ACC_ADDR_WR, ACC_NULL: begin
                            done  <= 1'b1;
                            rdata <= '0;
                        end
                        ACC_ADDR_RD: begin
                            done  <= 1'b1;
                            rdata <= addr_word;
                        end
                        ACC_DATA: begin
                            if (enabled) begin
                                state     <= ST_WAIT;
                                req_we    <= acc_we;
                                req_be    <= acc_be;
                                req_wdata <= wdata_clean;
                            end else begin
                                done  <= 1'b1;
                                rdata <= acc_we ? '0 : '1;
                            end
                        end
                        default: begin
                        end
                    endcase
                end
                ST_WAIT: begin
                    if (cfg_ack) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        if (req_we) begin
                            rdata <= '0;
                        end else if (cfg_miss) begin
                            rdata <= '1;
                        end else begin
                            rdata <= cfg_rdata;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port is free whenever no request is outstanding
    assign ready = (state == ST_IDLE);
    assign req   = (state == ST_WAIT);

endmodule

// File: rtl/cfgwin_port.sv
// Module: cfgwin_port
// Indirect configuration access port: address register at ADDR_OFF, data
// window at DATA_OFF. Address writes are repaired; partial or misplaced
// writes are dropped. Assumes one host access in flight at a time.
module cfgwin_port
    import cfgwin_pkg::*;
#(
    parameter int unsigned OFF_W    = 3,
    parameter int unsigned ADDR_OFF = 0,
    parameter int unsigned DATA_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_valid,
    input  logic              hst_we,
    input  logic [OFF_W-1:0]  hst_off,
    input  logic [LANES-1:0]  hst_be,
    input  logic [WORD_W-1:0] hst_wdata,
    output logic              hst_ready,
    output logic              hst_done,
    output logic [WORD_W-1:0] hst_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [BUS_W-1:0]  cfg_bus,
    output logic [DEV_W-1:0]  cfg_dev,
    output logic [FN_W-1:0]   cfg_fn,
    output logic [REG_W-1:0]  cfg_reg,
    output logic [LANES-1:0]  cfg_be,
    output logic [WORD_W-1:0] cfg_wdata,
    input  logic              cfg_ack,
    input  logic              cfg_miss,
    input  logic [WORD_W-1:0] cfg_rdata
);

    acc_kind_e         kind;
    logic [WORD_W-1:0] addr_word;
    logic              enabled;
    cfg_target_t       target;
    logic              take;

    // An access is taken only while the port is free
    assign take = hst_valid && hst_ready;

    cfgwin_decode #(
        .OFF_W    (OFF_W),
        .ADDR_OFF (ADDR_OFF),
        .DATA_OFF (DATA_OFF)
    ) u_decode (
        .take (take),
        .we   (hst_we),
        .off  (hst_off),
        .be   (hst_be),
        .kind (kind)
    );

    cfgwin_addr_reg u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (kind == ACC_ADDR_WR),
        .wr_val    (hst_wdata),
        .addr_word (addr_word),
        .enabled   (enabled),
        .target    (target)
    );

    cfgwin_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .acc_we    (hst_we),
        .acc_be    (hst_be),
        .acc_wdata (hst_wdata),
        .addr_word (addr_word),
        .enabled   (enabled),
        .cfg_ack   (cfg_ack),
        .cfg_miss  (cfg_miss),
        .cfg_rdata (cfg_rdata),
        .ready     (hst_ready),
        .done      (hst_done),
        .rdata     (hst_rdata),
        .req       (cfg_req),
        .req_we    (cfg_we),
        .req_be    (cfg_be),
        .req_wdata (cfg_wdata)
    );

    // Target fields come straight from the stored address
    assign cfg_bus = target.bus;
    assign cfg_dev = target.dev;
    assign cfg_fn  = target.fn;
    assign cfg_reg = target.regno;

endmodule

// File: rtl/cfgwin_chk.sv
// Module: cfgwin_chk
// Protocol and behaviour checks for cfgwin_port, attached by bind.
// Assumes reset is held low across at least one clock edge at start.
module cfgwin_chk
    import cfgwin_pkg::*;
#(
    parameter int unsigned OFF_W    = 3,
    parameter int unsigned ADDR_OFF = 0,
    parameter int unsigned DATA_OFF = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_valid,
    input logic              hst_we,
    input logic [OFF_W-1:0]  hst_off,
    input logic [LANES-1:0]  hst_be,
    input logic [WORD_W-1:0] hst_wdata,
    input logic              hst_ready,
    input logic              hst_done,
    input logic [WORD_W-1:0] hst_rdata,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic [BUS_W-1:0]  cfg_bus,
    input logic [DEV_W-1:0]  cfg_dev,
    input logic [FN_W-1:0]   cfg_fn,
    input logic [REG_W-1:0]  cfg_reg,
    input logic [LANES-1:0]  cfg_be,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic              cfg_ack,
    input logic              cfg_miss,
    input logic [WORD_W-1:0] addr_q
);

    localparam logic [OFF_W-1:0] AOFF = OFF_W'(ADDR_OFF);
    localparam logic [OFF_W-1:0] DOFF = OFF_W'(DATA_OFF);

    logic take;
    logic rst_seen = 1'b0;

    assign take = hst_valid && hst_ready;

    // Remember that the previous edge saw reset
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> (addr_q == '0 && hst_ready && !cfg_req && !hst_done));

    // R2
    addr_repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hst_we && hst_off == AOFF && (&hst_be)) |=>
        (addr_q[EN_BIT] && addr_q[1:0] == 2'b00 &&
         addr_q[EN_BIT-1:2] == $past(hst_wdata[EN_BIT-1:2])));

    // R3
    partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hst_we && hst_off == AOFF && !(&hst_be)) |=> $stable(addr_q));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=>
        (cfg_req && $stable({cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_be, cfg_wdata})));

    // R6
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_ack) |=> (hst_done && !cfg_req));

    // R7
    miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_ack && cfg_miss && !cfg_we) |=> (hst_rdata == '1));

    // R8
    lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_we) |-> ((cfg_wdata & ~lane_mask(cfg_be)) == '0));

    // R9
    disabled_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hst_off == DOFF && !addr_q[EN_BIT]) |=> (hst_done && !cfg_req));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !hst_ready);

    // R11
    reg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hst_off != DOFF) |=> hst_done);

endmodule

bind cfgwin_port cfgwin_chk #(
    .OFF_W    (OFF_W),
    .ADDR_OFF (ADDR_OFF),
    .DATA_OFF (DATA_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_valid (hst_valid),
    .hst_we    (hst_we),
    .hst_off   (hst_off),
    .hst_be    (hst_be),
    .hst_wdata (hst_wdata),
    .hst_ready (hst_ready),
    .hst_done  (hst_done),
    .hst_rdata (hst_rdata),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_bus   (cfg_bus),
    .cfg_dev   (cfg_dev),
    .cfg_fn    (cfg_fn),
    .cfg_reg   (cfg_reg),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_ack   (cfg_ack),
    .cfg_miss  (cfg_miss),
    .addr_q    (addr_word)
);

// File: tb/cfgwin_port_bench.sv
// Bench for cfgwin_port: a vector table for the address register, then
// directed tests for reset, the disabled window and downstream requests.
module cfgwin_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 14;

    typedef struct packed {
        logic        we;
        logic [2:0]  off;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 4'hF, 32'h0,        32'h0000_0000, 4'd1},  // R1 reset value
        '{1'b1, 3'd0, 4'hF, 32'h0001_2B07, 32'h0,        4'd2},  // R2 ill-formed write
        '{1'b0, 3'd0, 4'hF, 32'h0,        32'h8001_2B04, 4'd2},  // R2 repaired readback
        '{1'b1, 3'd0, 4'h3, 32'h1234_5678, 32'h0,        4'd3},  // R3 half-word write
        '{1'b1, 3'd0, 4'h7, 32'hFFFF_FFFF, 32'h0,        4'd3},  // R3 three-lane write
        '{1'b0, 3'd0, 4'hF, 32'h0,        32'h8001_2B04, 4'd3},  // R3 unchanged
        '{1'b1, 3'd1, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd4},  // R4 offset 1 write
        '{1'b1, 3'd6, 4'hF, 32'h0000_0001, 32'h0,        4'd4},  // R4 offset 6 write
        '{1'b0, 3'd0, 4'hF, 32'h0,        32'h8001_2B04, 4'd4},  // R4 unchanged
        '{1'b0, 3'd2, 4'hF, 32'h0,        32'h0000_0000, 4'd4},  // R4 unmapped read
        '{1'b1, 3'd0, 4'hF, 32'hFFFF_FFFF, 32'h0,        4'd2},  // R2 all ones
        '{1'b0, 3'd0, 4'hF, 32'h0,        32'hFFFF_FFFC, 4'd2},  // R2 low bits cleared
        '{1'b1, 3'd0, 4'hF, 32'h0000_0000, 32'h0,        4'd2},  // R2 enable missing
        '{1'b0, 3'd0, 4'h1, 32'h0,        32'h8000_0000, 4'd2}   // R2 partial-strobe read
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hst_valid;
    logic        hst_we;
    logic [2:0]  hst_off;
    logic [3:0]  hst_be;
    logic [31:0] hst_wdata;
    logic        hst_ready;
    logic        hst_done;
    logic [31:0] hst_rdata;
    logic        cfg_req;
    logic        cfg_we;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack;
    logic        cfg_miss;
    logic [31:0] cfg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [21:0] exp_tgt;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgwin_port u_cfgwin_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .hst_valid (hst_valid),
        .hst_we    (hst_we),
        .hst_off   (hst_off),
        .hst_be    (hst_be),
        .hst_wdata (hst_wdata),
        .hst_ready (hst_ready),
        .hst_done  (hst_done),
        .hst_rdata (hst_rdata),
        .cfg_req   (cfg_req),
        .cfg_we    (cfg_we),
        .cfg_bus   (cfg_bus),
        .cfg_dev   (cfg_dev),
        .cfg_fn    (cfg_fn),
        .cfg_reg   (cfg_reg),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_ack   (cfg_ack),
        .cfg_miss  (cfg_miss),
        .cfg_rdata (cfg_rdata)
    );

    // Compare one value and count the result
    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply reset for a few cycles
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check32("R1 ready", {31'd0, hst_ready}, 32'd1);
        check32("R1 req", {31'd0, cfg_req}, 32'd0);
        check32("R1 done", {31'd0, hst_done}, 32'd0);
    endtask

    // One access that completes without the engine
    task automatic reg_acc(input logic we, input logic [2:0] off, input logic [3:0] be,
                           input logic [31:0] wd, output logic [31:0] rd, input string tag);
        @(negedge clk);
        hst_valid = 1'b1;
        hst_we    = we;
        hst_off   = off;
        hst_be    = be;
        hst_wdata = wd;
        @(negedge clk);
        hst_valid = 1'b0;
        check32({tag, " R11 done"}, {31'd0, hst_done}, 32'd1);
        rd = hst_rdata;
    endtask

    // One data-window access answered by the modelled engine
    task automatic data_acc(input logic we, input logic [3:0] be, input logic [31:0] wd,
                            input int waits, input logic [31:0] resp, input logic miss,
                            input logic [31:0] exp_wd, input logic [31:0] exp_rd,
                            input string tag);
        @(negedge clk);
        hst_valid = 1'b1;
        hst_we    = we;
        hst_off   = 3'd4;
        hst_be    = be;
        hst_wdata = wd;
        @(negedge clk);
        // conflicting address write held while busy (R10)
        hst_we    = 1'b1;
        hst_off   = 3'd0;
        hst_be    = 4'hF;
        hst_wdata = 32'h0000_0000;
        check32({tag, " R6 req up"}, {31'd0, cfg_req}, 32'd1);
        check32({tag, " R6 we"}, {31'd0, cfg_we}, {31'd0, we});
        check32({tag, " R6 be"}, {28'd0, cfg_be}, {28'd0, be});
        check32({tag, " R5 target"}, {10'd0, cfg_bus, cfg_dev, cfg_fn, cfg_reg}, {10'd0, exp_tgt});
        check32({tag, " R10 ready low"}, {31'd0, hst_ready}, 32'd0);
        if (we) begin
            check32({tag, " R8 wdata"}, cfg_wdata, exp_wd);
        end
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            check32({tag, " R6 held"}, {31'd0, cfg_req}, 32'd1);
        end
        hst_valid = 1'b0;
        cfg_ack   = 1'b1;
        cfg_miss  = miss;
        cfg_rdata = resp;
        @(negedge clk);
        cfg_ack   = 1'b0;
        cfg_miss  = 1'b0;
        check32({tag, " R6 done"}, {31'd0, hst_done}, 32'd1);
        check32({tag, " R6 req down"}, {31'd0, cfg_req}, 32'd0);
        if (!we) begin
            check32({tag, " rdata"}, hst_rdata, exp_rd);
        end
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Main stimulus
    initial begin
        logic [31:0] rd;
        rst_n     = 1'b0;
        hst_valid = 1'b0;
        hst_we    = 1'b0;
        hst_off   = 3'd0;
        hst_be    = 4'h0;
        hst_wdata = 32'h0;
        cfg_ack   = 1'b0;
        cfg_miss  = 1'b0;
        cfg_rdata = 32'h0;
        do_reset();

        // R9: enable bit still clear after reset
        reg_acc(1'b0, 3'd4, 4'hF, 32'h0, rd, "R9 read");
        check32("R9 read ones", rd, 32'hFFFF_FFFF);
        check32("R9 no req", {31'd0, cfg_req}, 32'd0);
        reg_acc(1'b1, 3'd4, 4'hF, 32'h1111_2222, rd, "R9 write");
        check32("R9 no req on write", {31'd0, cfg_req}, 32'd0);

        // Address register vector table
        for (int v = 0; v < NV; v++) begin
            reg_acc(VECS[v].we, VECS[v].off, VECS[v].be, VECS[v].wd, rd,
                    $sformatf("R%0d vec%0d", VECS[v].req, v));
            if (!VECS[v].we) begin
                check32($sformatf("R%0d vec%0d read", VECS[v].req, v), rd, VECS[v].exp);
            end
        end

        // R5 R6: read through the window with a slow engine
        reg_acc(1'b1, 3'd0, 4'hF, 32'h00AB_5A9D, rd, "R2 set addr");
        exp_tgt = {8'hAB, 5'd11, 3'd2, 6'd39};
        data_acc(1'b0, 4'hF, 32'h0, 3, 32'h1234_ABCD, 1'b0, 32'h0, 32'h1234_ABCD, "R6 read");
        reg_acc(1'b0, 3'd0, 4'hF, 32'h0, rd, "R10 addr");
        check32("R10 busy write dropped", rd, 32'h80AB_5A9C);

        // R7: no device answered
        data_acc(1'b0, 4'h1, 32'h0, 0, 32'h5555_5555, 1'b1, 32'h0, 32'hFFFF_FFFF, "R7 miss");

        // R8: sparse write lanes, extreme target fields
        reg_acc(1'b1, 3'd0, 4'hF, 32'h00FF_FFFF, rd, "R2 set addr2");
        exp_tgt = {8'hFF, 5'd31, 3'd7, 6'd63};
        data_acc(1'b1, 4'b0101, 32'hAABB_CCDD, 1, 32'h0, 1'b1, 32'h00BB_00DD, 32'h0, "R8 write");
        data_acc(1'b1, 4'b1000, 32'h1234_5678, 0, 32'h0, 1'b0, 32'h1200_0000, 32'h0, "R8 top lane");

        // R1: reset clears a programmed address
        do_reset();
        reg_acc(1'b0, 3'd0, 4'hF, 32'h0, rd, "R1 addr");
        check32("R1 addr cleared", rd, 32'h0000_0000);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule